// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host writes it over a three-wire serial link: a serial clock, a data line and a load strobe. A fourth input, the freeze strobe, controls when the outputs change. Each command carries a channel select, a span bit and an 8-bit code. For every channel the block drives the code and the span bit to the analog converter. The analog converter, its reference buffers and its output amplifiers are outside this block.

Every channel has two register ranks. The first rank is a holding register that takes the addressed word when the load strobe falls. The second rank is an output register, and only it reaches the analog side. While freeze is low, a load writes straight through to the output. While freeze is high, the outputs stay as they are. When freeze later goes from high to low, all four outputs take their holding values in the same cycle. This lets a host prepare new values for all channels and apply them together.

All four serial inputs are sampled by a fast system clock through multi-stage synchronizers. Edges are found in the system clock domain, so the serial link needs no clock of its own inside the chip.

Top module: `qdac_serial_if`

## Requirements
- R1: While reset is asserted, and in the cycle after it, every channel's output code and span bit are 0. Every holding register is also 0.
- R2: A data bit is shifted in only on a falling edge of the serial clock while load is high. Serial clock edges that occur while load is low leave the shift register unchanged.
- R3: A command is 11 bits sent most significant bit first. The order on the wire is select[1], select[0], span, then code[7] down to code[0].
- R4: Select value 0 addresses channel A (code bits 7:0 of `dac_code`). Value 1 addresses B (15:8), value 2 addresses C (23:16) and value 3 addresses D (31:24).
- R5: The span bit is stored together with the code. It appears on bit n of `dac_span` for channel n (A=0 to D=3). 0 selects 1x of the reference and 1 selects 2x.
- R6: When load falls while freeze is low, the addressed channel's output takes the new word. No other channel's output changes.
- R7: While freeze is high, no output changes, whatever is loaded. A rising edge of freeze also changes no output.
- R8: A high-to-low transition of freeze copies all four holding registers to the outputs in one cycle. Each holding register holds the last word loaded for its channel.
- R9: A word may be sent with more than 11 clocks, for example 16. Only the last 11 bits shifted before load falls are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; a bit is taken on its falling edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_ld | input | 1 | Load strobe; its falling edge transfers the word |
| freeze | input | 1 | High holds the outputs; a high-to-low edge commits all channels |
| dac_code | output | 32 | Four 8-bit output codes, channel A in the low byte |
| dac_span | output | 4 | Per-channel span bit, channel A in bit 0 |

## Verification
The bench uses the default synchronizer depth of two stages and the package sizes of four channels with 8-bit codes. With these settings every select value, both span values and the full 11-bit word can be reached. It drives words of 11 and 16 clocks, with freeze both low and high, and it includes a freeze rising edge that must have no effect. It also clocks junk bits while load is low. A random phase mixes channels, word lengths and freeze transitions, and checks the outputs against a two-rank model kept in the bench.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int CODE_W = 8;
    localparam int NUM_CH = 4;
    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int WORD_W = SEL_W + 1 + CODE_W;

    typedef logic [SEL_W-1:0] ch_sel_t;

    typedef struct packed {
        logic              span;
        logic [CODE_W-1:0] code;
    } chan_val_t;

    // Packed field order equals serial order: select first, then span, then code.
    typedef struct packed {
        ch_sel_t   sel;
        chan_val_t val;
    } cmd_t;

    localparam chan_val_t CHAN_RST = '0;

    function automatic cmd_t unpack_word(input logic [WORD_W-1:0] w);
        return cmd_t'(w);
    endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     pass_thru,
    input  logic                     commit_all,
    input  cmd_t                     cmd,
    output logic [NUM_CH*CODE_W-1:0] out_code,
    output logic [NUM_CH-1:0]        out_span,
    output logic [NUM_CH*CODE_W-1:0] hold_code,
    output logic [NUM_CH-1:0]        hold_span
);
    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            chan_val_t hold_q, out_q;
            logic      hit;

            assign hit = wr_en && (cmd.sel == ch_sel_t'(ch));

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= CHAN_RST;
                    out_q  <= CHAN_RST;
                end else begin
                    if (hit) hold_q <= cmd.val;
                    if (hit && pass_thru) out_q <= cmd.val;
                    else if (commit_all)  out_q <= hold_q;
                end
            end

            assign out_code[ch*CODE_W +: CODE_W]  = out_q.code;
            assign out_span[ch]                   = out_q.span;
            assign hold_code[ch*CODE_W +: CODE_W] = hold_q.code;
            assign hold_span[ch]                  = hold_q.span;
        end
    endgenerate
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk,
    input  logic                     ser_dat,
    input  logic                     ser_ld,
    input  logic                     freeze,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_span
);
    logic [3:0] pins_s;
    logic       sclk_s, dat_s, ld_s, frz_s;
    logic       sclk_q, ld_q, frz_q;
    logic       sclk_fall, ld_fall, frz_fall;
    logic [WORD_W-1:0]        shreg;
    cmd_t                     cmd;
    logic [NUM_CH*CODE_W-1:0] hold_code;
    logic [NUM_CH-1:0]        hold_span;

    qdac_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk, ser_dat, ser_ld, freeze}),
        .q   (pins_s)
    );

    assign {sclk_s, dat_s, ld_s, frz_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            ld_q   <= 1'b0;
            frz_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            ld_q   <= ld_s;
            frz_q  <= frz_s;
        end
    end

    assign sclk_fall = sclk_q & ~sclk_s;
    assign ld_fall   = ld_q   & ~ld_s;
    assign frz_fall  = frz_q  & ~frz_s;

    qdac_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_fall & ld_s),
        .bit_in   (dat_s),
        .word     (shreg)
    );

    assign cmd = unpack_word(shreg);

    qdac_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ld_fall),
        .pass_thru  (~frz_s),
        .commit_all (frz_fall),
        .cmd        (cmd),
        .out_code   (dac_code),
        .out_span   (dac_span),
        .hold_code  (hold_code),
        .hold_span  (hold_span)
    );
endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk
    import qdac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     frz_s,
    input logic                     frz_fall,
    input logic                     ld_fall,
    input logic [NUM_CH*CODE_W-1:0] hold_code,
    input logic [NUM_CH-1:0]        hold_span,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_span
);
    logic [NUM_CH*CODE_W-1:0] code_prev;
    logic [NUM_CH-1:0]        span_prev;
    logic                     frz_fall_q;
    logic [NUM_CH-1:0]        chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_prev  <= '0;
            span_prev  <= '0;
            frz_fall_q <= 1'b0;
        end else begin
            code_prev  <= dac_code;
            span_prev  <= dac_span;
            frz_fall_q <= frz_fall;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            chg[i] = (dac_code[i*CODE_W +: CODE_W] != code_prev[i*CODE_W +: CODE_W])
                   || (dac_span[i] != span_prev[i]);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && (dac_span == '0) && (hold_code == '0));

    p_frozen_stable_r7: assert property (@(posedge clk) disable iff (rst)
        frz_s |=> $stable(dac_code) && $stable(dac_span));

    p_one_channel_r6: assert property (@(posedge clk) disable iff (rst)
        !frz_fall_q |-> $countones(chg) <= 1);

    p_commit_all_r8: assert property (@(posedge clk) disable iff (rst)
        (frz_fall && !ld_fall) |=> (dac_code == $past(hold_code)) && (dac_span == $past(hold_span)));
endmodule

bind qdac_serial_if qdac_serial_if_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frz_s     (frz_s),
    .frz_fall  (frz_fall),
    .ld_fall   (ld_fall),
    .hold_code (hold_code),
    .hold_span (hold_span),
    .dac_code  (dac_code),
    .dac_span  (dac_span)
);

// File: tb/qdac_serial_if_tb.sv
`timescale 1ns/1ps
module qdac_serial_if_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b1, freeze = 1'b0;
    logic [31:0] dac_code;
    logic [3:0]  dac_span;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [8:0]  hold_m [4];
    logic [8:0]  out_m  [4];
    logic        frz_m = 1'b0;
    logic [10:0] last_w = '0;

    always #2.5 clk = ~clk;

    qdac_serial_if u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .freeze(freeze), .dac_code(dac_code), .dac_span(dac_span)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [10:0] mk_word(input logic [1:0] sel, input logic span, input logic [7:0] code);
        return {sel, span, code};
    endfunction

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            n_chk++;
            if ({dac_span[c], dac_code[c*8 +: 8]} !== out_m[c]) begin
                n_bad++;
                $display("FAIL %s ch%0d: actual span=%0b code=%02h expected span=%0b code=%02h",
                         tag, c, dac_span[c], dac_code[c*8 +: 8], out_m[c][8], out_m[c][7:0]);
            end
        end
    endtask

    task automatic clock_bit(input logic b);
        ser_dat = b; ser_clk = 1'b1; wait_cyc(4);
        ser_clk = 1'b0; wait_cyc(4);
    endtask

    // lead: number of junk bits sent ahead of the 11-bit word
    task automatic send(input logic [10:0] w, input int lead);
        for (int i = 0; i < lead; i++) clock_bit(1'($urandom));
        for (int i = 10; i >= 0; i--) clock_bit(w[i]);
        last_w = w;
    endtask

    task automatic model_load();
        hold_m[last_w[10:9]] = last_w[8:0];
        if (!frz_m) out_m[last_w[10:9]] = last_w[8:0];
    endtask

    task automatic do_load();
        ser_ld = 1'b0; wait_cyc(6);
        model_load();
        ser_ld = 1'b1; wait_cyc(6);
    endtask

    task automatic set_freeze(input logic v);
        if (frz_m && !v) for (int c = 0; c < 4; c++) out_m[c] = hold_m[c];
        frz_m = v; freeze = v; wait_cyc(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 4; c++) begin hold_m[c] = '0; out_m[c] = '0; end
        wait_cyc(6);
        check_all("R1 during reset");
        rst = 1'b0; wait_cyc(3);
        check_all("R1 after reset");

        // R3 R4 R5 R6: each channel directly, freeze low
        send(mk_word(2'd0, 1'b1, 8'hA5), 0); do_load(); check_all("R3 R4 R6 ch A");
        send(mk_word(2'd1, 1'b0, 8'h5A), 0); do_load(); check_all("R4 R5 ch B");
        send(mk_word(2'd2, 1'b1, 8'h81), 0); do_load(); check_all("R4 R5 ch C");
        send(mk_word(2'd3, 1'b0, 8'h3C), 0); do_load(); check_all("R4 R6 ch D");

        // R9: 16-clock word, five junk bits in front
        send(mk_word(2'd1, 1'b1, 8'hFE), 5); do_load(); check_all("R9 16-clock word");

        // R2: clocks while load is low must not shift
        send(mk_word(2'd0, 1'b0, 8'h11), 0);
        ser_ld = 1'b0; wait_cyc(6); model_load();
        for (int i = 0; i < 11; i++) clock_bit(1'b1);
        ser_ld = 1'b1; wait_cyc(6);
        do_load();
        check_all("R2 shift gated by load");

        // R7: frozen loads, then freeze rising edge alone
        set_freeze(1'b1); check_all("R7 freeze rise");
        send(mk_word(2'd2, 1'b0, 8'h42), 0); do_load(); check_all("R7 frozen load C");
        send(mk_word(2'd3, 1'b1, 8'hC7), 5); do_load(); check_all("R7 frozen load D");
        send(mk_word(2'd0, 1'b1, 8'h00), 0); do_load(); check_all("R7 frozen load A");
        // R8: commit of all holding registers
        set_freeze(1'b0); check_all("R8 commit all");
        // commit with unchanged holding registers again
        set_freeze(1'b1); set_freeze(1'b0); check_all("R8 repeat commit");

        // random phase
        for (int k = 0; k < 40; k++) begin
            logic [10:0] w;
            w = 11'($urandom);
            send(w, ($urandom % 2) ? 5 : 0);
            do_load();
            check_all("R3 R6 R7 random load");
            if (($urandom % 3) == 0) begin
                set_freeze(~frz_m);
                check_all("R7 R8 random freeze");
            end
        end
        set_freeze(1'b0); check_all("R8 final commit");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule